// File: doc/BRIEF.md
# Configuration lock key sequencer

This block sits beside a general-purpose I/O port and guards its pin-mode configuration. It observes bus writes and reads aimed at one 32-bit lock register. The low 16 bits of that register name the pins that should be locked. Bit 16 is the key bit. Until the lock engages, the 16 selection bits behave as an ordinary read/write register.

The lock engages only after three back-to-back writes to the register: key bit high, then key bit low, then key bit high, with identical selection bits each time. When the third write completes, the selection is frozen into a 16-bit lock mask that stays in force until reset. The port uses the mask to refuse pin-mode configuration writes for locked pins, while writes to output levels keep passing for every pin. Software confirms the lock by reading the register twice. The first read after engagement returns key 0 and the second returns key 1.

Top module: `lkseq_top`

## Requirements
- R1: During and after reset, `lock_active` is 0, `lock_mask` is 0 and `rdata` is 0.
- R2: While unlocked, every write stores `wdata[15:0]` as the selection. A read presents `{15'b0, key=0 at bit 16, selection at bits 15:0}` on `rdata` after the clock edge that samples `rd_en`. Upper write bits are ignored.
- R3: Three consecutive writes form the key. The first has `wdata[16]`=1, the second has `wdata[16]`=0 and the third has `wdata[16]`=1, with equal `wdata[15:0]` in all three. After the edge of the third write, `lock_active` is 1 and `lock_mask` equals that selection. After only the first two writes, `lock_active` is still 0.
- R4: If `wdata[15:0]` differs between any two writes of the key, the sequence is abandoned and no lock engages.
- R5: A key write that arrives out of order sends the sequencer back to idle without locking. Two examples are key=1 followed by key=1, and key=0 as the first write. A later correct three-write key still locks.
- R6: Once locked, the first read returns bit 16 as 0 and all later reads return bit 16 as 1. In both cases bits 15:0 hold the frozen mask.
- R7: Once locked, writes to the register are ignored, including a complete new key sequence. `lock_mask` and the read value stay unchanged.
- R8: `cfg_grant[i]` = `cfg_req[i]` AND NOT `lock_mask[i]` for each pin. `out_grant` always equals `out_req`, whether locked or not.
- R9: Reset clears an engaged lock, and the sequence can then lock a different mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the lock register |
| rd_en | input | 1 | Read strobe for the lock register |
| wdata | input | 32 | Write data; bit 16 key, bits 15:0 selection |
| rdata | output | 32 | Registered read data |
| lock_mask | output | 16 | Frozen per-pin lock mask (0 while unlocked) |
| lock_active | output | 1 | Lock has engaged |
| cfg_req | input | 16 | Per-pin mode configuration write requests |
| cfg_grant | output | 16 | Configuration requests allowed through |
| out_req | input | 16 | Per-pin output level write requests |
| out_grant | output | 16 | Output level requests allowed through |

## Verification
The bench targets several ways a sequencer can go wrong:
- A sequence whose selection bits change only on the second or only on the third write. A design that compared against the wrong write would lock a mask that software never confirmed.
- Repeated key=1 writes. A design that merely re-armed would lock on 1,1,0,1.
- The two reads after engagement. A design that got this wrong would report key 1 immediately or never.
- A full new key sequence after locking. A design that still accepted writes would silently widen or narrow the frozen mask.

Configuration and output grants are compared across lock states, and a reset followed by a fresh lock checks that the frozen state really clears.

// File: rtl/lkseq_pkg.sv
// Package: shared types and constants for the lock key sequencer.
// Assumes a single lock register with the key bit directly above the
// selection field.
package lkseq_pkg;

    // Progress through the three-write key.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,   // waiting for first key=1 write
        SQ_ARMED  = 2'd1,   // saw key=1, expecting key=0 same bits
        SQ_PRIMED = 2'd2,   // saw key=1,0, expecting key=1 same bits
        SQ_LOCKED = 2'd3    // mask frozen until reset
    } seq_state_e;

endpackage

// File: rtl/lkseq_fsm.sv
// Module: lkseq_fsm
// Tracks the write-1 / write-0 / write-1 key on the key bit and keeps the
// selection register. Assumes at most one write per cycle; once locked,
// all writes are dropped until reset.
module lkseq_fsm
    import lkseq_pkg::*;
#(
    parameter int PIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_key,
    input  logic [PIN_W-1:0] wr_sel,
    output logic             active,
    output logic [PIN_W-1:0] sel_q,
    output logic [PIN_W-1:0] lock_mask
);

    seq_state_e       state_q, state_d;
    logic [PIN_W-1:0] ref_q, ref_d;
    logic             same_sel;

    assign same_sel = (wr_sel == ref_q);

    // Next-state decision for the key sequence.
    always_comb begin
        state_d = state_q;
        ref_d   = ref_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (wr_en && wr_key) begin
                    state_d = SQ_ARMED;
                    ref_d   = wr_sel;
                end
            end
            SQ_ARMED: begin
                if (wr_en) begin
                    state_d = (!wr_key && same_sel) ? SQ_PRIMED : SQ_IDLE;
                end
            end
            SQ_PRIMED: begin
                if (wr_en) begin
                    state_d = (wr_key && same_sel) ? SQ_LOCKED : SQ_IDLE;
                end
            end
            SQ_LOCKED: state_d = SQ_LOCKED;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // Sequence state and reference selection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_d;
        end
    end

    // Selection register: ordinary storage until the lock engages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en && (state_q != SQ_LOCKED)) begin
            sel_q <= wr_sel;
        end
    end

    assign active    = (state_q == SQ_LOCKED);
    assign lock_mask = active ? sel_q : '0;

endmodule

// File: rtl/lkseq_readback.sv
// Module: lkseq_readback
// Builds registered read data for the lock register. Assumes the key bit
// sits at position PIN_W; reports key 1 only from the second read after
// the lock engaged.
module lkseq_readback #(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              active,
    input  logic [PIN_W-1:0]  sel_q,
    output logic [DATA_W-1:0] rdata
);

    localparam int KEY_POS = PIN_W;

    logic              seen_q;
    logic [DATA_W-1:0] word;

    // Compose the word presented for this read.
    always_comb begin
        word              = '0;
        word[PIN_W-1:0]   = sel_q;
        word[KEY_POS]     = active && seen_q;
    end

    // Remember the first read after engagement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (rd_en && active) begin
            seen_q <= 1'b1;
        end
    end

    // Capture read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= word;
        end
    end

endmodule

// File: rtl/lkseq_gate.sv
// Module: lkseq_gate
// Per-pin gating of port write requests. Mode configuration requests are
// blocked for locked pins; output level requests always pass.
module lkseq_gate #(
    parameter int PIN_W = 16
) (
    input  logic [PIN_W-1:0] lock_mask,
    input  logic [PIN_W-1:0] cfg_req,
    output logic [PIN_W-1:0] cfg_grant,
    input  logic [PIN_W-1:0] out_req,
    output logic [PIN_W-1:0] out_grant
);

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign cfg_grant[i] = cfg_req[i] & ~lock_mask[i];
        assign out_grant[i] = out_req[i];
    end

endmodule

// File: rtl/lkseq_top.sv
// Module: lkseq_top
// Lock key sequencer for one I/O port. Assumes the bus presents at most
// one write and one read strobe per cycle to the lock register; upper
// write bits above the key are ignored.
module lkseq_top #(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PIN_W-1:0]  lock_mask,
    output logic              lock_active,
    input  logic [PIN_W-1:0]  cfg_req,
    output logic [PIN_W-1:0]  cfg_grant,
    input  logic [PIN_W-1:0]  out_req,
    output logic [PIN_W-1:0]  out_grant
);

    localparam int KEY_POS = PIN_W;

    logic [PIN_W-1:0] sel_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:KEY_POS+1];

    lkseq_fsm #(.PIN_W(PIN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_key    (wdata[KEY_POS]),
        .wr_sel    (wdata[PIN_W-1:0]),
        .active    (lock_active),
        .sel_q     (sel_q),
        .lock_mask (lock_mask)
    );

    lkseq_readback #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .active (lock_active),
        .sel_q  (sel_q),
        .rdata  (rdata)
    );

    lkseq_gate #(.PIN_W(PIN_W)) u_gate (
        .lock_mask (lock_mask),
        .cfg_req   (cfg_req),
        .cfg_grant (cfg_grant),
        .out_req   (out_req),
        .out_grant (out_grant)
    );

endmodule

// File: rtl/lkseq_checks.sv
// Module: lkseq_checks
// Property checker for lkseq_top, attached by bind below.
module lkseq_checks #(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [PIN_W-1:0]  lock_mask,
    input logic              lock_active,
    input logic [PIN_W-1:0]  cfg_grant
);

    // R1: reset leaves the block unlocked with cleared read data.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!lock_active && rdata == '0));

    // R3: engagement is caused by a key=1 write carrying the frozen mask.
    p_lock_by_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_active) |-> ($past(wr_en) && $past(wdata[PIN_W])));

    p_lock_mask_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_active) |-> (lock_mask == $past(wdata[PIN_W-1:0])));

    // R6: key bit never reads 1 unless locked, and not right at engagement.
    p_key_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[PIN_W] |-> lock_active);

    p_first_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_active) |-> !rdata[PIN_W]);

    // R7: once locked, the lock and its mask hold until reset.
    p_mask_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> (lock_active && $stable(lock_mask)));

    // R8: no configuration grant for a locked pin.
    p_cfg_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_grant & lock_mask) == '0);

endmodule

bind lkseq_top lkseq_checks #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .lock_mask   (lock_mask),
    .lock_active (lock_active),
    .cfg_grant   (cfg_grant)
);

// File: tb/lkseq_top_test.sv
// Bench for lkseq_top: scoreboard of expected read words plus direct
// checks of the lock outputs and grants.
module lkseq_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] lock_mask;
    logic        lock_active;
    logic [15:0] cfg_req = '0;
    logic [15:0] cfg_grant;
    logic [15:0] out_req = '0;
    logic [15:0] out_grant;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    lkseq_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .lock_mask(lock_mask),
        .lock_active(lock_active), .cfg_req(cfg_req), .cfg_grant(cfg_grant),
        .out_req(out_req), .out_grant(out_grant)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic key, input logic [15:0] sel);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = {15'h5A5A, key, sel};   // junk in upper bits
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue a read and queue the expected word.
    task automatic rd(input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: compare read data just after the sampling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                #1;
                if (exp_q.size() == 0) begin
                    check(rdata, 32'hx, "unexpected read");
                end else begin
                    check(rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({31'b0, lock_active}, 32'd0, "R1 active in reset");
        check({16'b0, lock_mask}, 32'd0, "R1 mask in reset");
        check(rdata, 32'd0, "R1 rdata in reset");
        rst_n = 1'b1;

        // R2: ordinary register before lock.
        wr(1'b0, 16'h1234);
        rd(32'h0000_1234, "R2 readback");
        cfg_req = 16'hFFFF;
        out_req = 16'hFFFF;
        #1;
        check({16'b0, cfg_grant}, 32'h0000_FFFF, "R8 cfg unlocked");
        wr(1'b1, 16'hABCD);
        rd(32'h0000_ABCD, "R2 key write key reads 0");
        check({31'b0, lock_active}, 32'd0, "R2 not locked");
        wr(1'b0, 16'h0000);            // abandons armed state

        // R4: selection change on second, then on third write.
        wr(1'b1, 16'h00F0); wr(1'b0, 16'h00F1); wr(1'b1, 16'h00F0);
        wr(1'b0, 16'h0000);
        check({31'b0, lock_active}, 32'd0, "R4 change on second write");
        wr(1'b1, 16'h00F0); wr(1'b0, 16'h00F0); wr(1'b1, 16'h00F1);
        check({31'b0, lock_active}, 32'd0, "R4 change on third write");
        check({16'b0, lock_mask}, 32'd0, "R4 mask stays clear");

        // R5: out-of-order key writes.
        wr(1'b1, 16'h000F); wr(1'b1, 16'h000F); wr(1'b0, 16'h000F);
        wr(1'b1, 16'h000F);
        check({31'b0, lock_active}, 32'd0, "R5 1,1,0,1 no lock");
        wr(1'b0, 16'h0000);
        rd(32'h0000_0000, "R5 readback after abort");

        // R3: correct key.
        wr(1'b1, 16'hC3A5); wr(1'b0, 16'hC3A5);
        check({31'b0, lock_active}, 32'd0, "R3 not yet after two writes");
        wr(1'b1, 16'hC3A5);
        check({31'b0, lock_active}, 32'd1, "R3 locked");
        check({16'b0, lock_mask}, 32'h0000_C3A5, "R3 mask");

        // R8: grants when locked.
        #1;
        check({16'b0, cfg_grant}, 32'h0000_3C5A, "R8 cfg gated");
        check({16'b0, out_grant}, 32'h0000_FFFF, "R8 out passes");

        // R6: confirm reads.
        rd(32'h0000_C3A5, "R6 first read key 0");
        rd(32'h0001_C3A5, "R6 second read key 1");
        rd(32'h0001_C3A5, "R6 third read key 1");

        // R7: writes ignored after lock.
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'hFFFF); wr(1'b0, 16'hFFFF); wr(1'b1, 16'hFFFF);
        check({16'b0, lock_mask}, 32'h0000_C3A5, "R7 mask unchanged");
        rd(32'h0001_C3A5, "R7 readback unchanged");

        // R9: reset clears, then relock with another mask.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check({31'b0, lock_active}, 32'd0, "R9 reset unlocks");
        check({16'b0, lock_mask}, 32'd0, "R9 mask cleared");
        wr(1'b1, 16'h8001); wr(1'b0, 16'h8001); wr(1'b1, 16'h8001);
        check({16'b0, lock_mask}, 32'h0000_8001, "R9 relock mask");
        rd(32'h0000_8001, "R9 first read key 0");
        rd(32'h0001_8001, "R9 second read key 1");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check(exp_q.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule